// File: doc/BRIEF.md
# Dword Circular-Buffer Message Mailbox

A one-direction message channel from a producer to a consumer, built on a circular buffer of 32-bit slots. Each producer write pushes one slot, and each consumer read pops the oldest slot. A message is a header word followed by payload words, so the largest payload is DEPTH*4 - 4 bytes. The producer gives the number of valid bytes in the last, partial word, and the block fills the unused upper bytes with zeros.

A status word packs the fixed depth together with two free-running 8-bit pointers. Software can compute the filled count as (write - read) mod 256, and the free count as depth minus filled. When a full message is in the buffer, the producer raises a notify request and the block sends a one-cycle notify pulse to the consumer. A write into a full buffer is dropped and sets a sticky overflow flag. A read from an empty buffer returns zero.

Top module: `dword_mailbox`

## Requirements
- R1: After reset, the status word reads {DEPTH, 8'h00, 8'h00, 8'h00}, and overflow_o, rd_data and notify_o are all zero.
- R2: The status word layout is: bits [31:24] the depth, bits [23:16] the write pointer, bits [15:8] the read pointer, bits [7:0] always zero.
- R3: A write accepted at a clock edge stores one slot and increments the write pointer by one, modulo 256. The filled count (write pointer - read pointer) mod 256 never exceeds DEPTH.
- R4: rd_en is sampled at a clock edge. In the cycle after it, rd_data shows the oldest slot and the read pointer has incremented by one. rd_data holds its value while rd_en is low.
- R5: Both pointers run freely and wrap from 255 to 0. First-in first-out order is kept across the wrap.
- R6: A write while the buffer holds DEPTH slots, with no read in the same cycle, is discarded. The write pointer does not change, and overflow_o becomes 1 and stays 1 until reset.
- R7: A read while the buffer is empty sets rd_data to zero and leaves the read pointer unchanged.
- R8: A read and a write in the same cycle on a full buffer both take effect. The filled count stays at DEPTH, and overflow_o does not change.
- R9: wr_bytes selects the number of valid low-order bytes: 0 means 4, and 1 to 3 mean that many. The bytes above them are stored as zero.
- R10: Each cycle in which notify_req is high produces notify_o high in the next cycle. notify_o is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Producer write-window strobe, one slot per cycle |
| wr_data | input | 32 | Word to store |
| wr_bytes | input | 2 | Valid byte count of the word, 0 means all four |
| rd_en | input | 1 | Consumer read-window strobe, one slot per cycle |
| rd_data | output | 32 | Oldest slot, registered, updated after each read |
| status | output | 32 | {depth, write pointer, read pointer, 8'h00} |
| overflow_o | output | 1 | Sticky flag for a dropped write |
| notify_o | output | 1 | One-cycle notify pulse to the consumer |
| notify_req | input | 1 | Producer request for a notify pulse |

## Verification
The assertions rely on three things about the inputs: the strobes are never X after reset, each strobe means at most one slot per cycle, and reset is held for at least one edge. The bench drives every input at the falling edge from fully defined values. It mixes random single-cycle strobes, with a fixed seed, with directed sequences that fill the buffer to DEPTH, push past it, drain it, read it while empty and run the pointers past 255. This keeps stimulus inside those assumptions while reaching every boundary of the filled count.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WORD_W = 32;
    localparam int PTR_W  = 8;

    typedef struct packed {
        logic              ovf;
        logic              notify;
        logic [WORD_W-1:0] rdata;
    } mbx_ctrl_t;

    function automatic logic [WORD_W-1:0] pad_word(logic [WORD_W-1:0] w, logic [1:0] nbytes);
        logic [WORD_W-1:0] m;
        case (nbytes)
            2'd1:    m = 32'h0000_00FF;
            2'd2:    m = 32'h0000_FFFF;
            2'd3:    m = 32'h00FF_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return w & m;
    endfunction
endpackage

// File: rtl/mbx_ptr.sv
module mbx_ptr #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    output logic [mbx_pkg::PTR_W-1:0] ptr,
    output logic [IDX_W-1:0]        idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [mbx_pkg::PTR_W-1:0] ptr_d, ptr_q;
    logic [IDX_W-1:0]          idx_d, idx_q;

    // Free-running software pointer plus a storage index that wraps at DEPTH
    always_comb begin
        ptr_d = ptr_q;
        idx_d = idx_q;
        if (adv) begin
            ptr_d = ptr_q + 1'b1;
            idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            idx_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            idx_q <= idx_d;
        end
    end

    assign ptr = ptr_q;
    assign idx = idx_q;
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           widx,
    input  logic [mbx_pkg::WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]           ridx,
    output logic [mbx_pkg::WORD_W-1:0] rdata
);
    logic [mbx_pkg::WORD_W-1:0] mem_d [DEPTH];
    logic [mbx_pkg::WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (we && (widx == IDX_W'(i))) mem_d[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/dword_mailbox.sv
module dword_mailbox #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic [1:0]  wr_bytes,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic [31:0] status,
    output logic        overflow_o,
    output logic        notify_o,
    input  logic        notify_req
);
    import mbx_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] DEPTH8 = PTR_W'(DEPTH);

    logic [PTR_W-1:0]  wptr, rptr, filled;
    logic [IDX_W-1:0]  widx, ridx;
    logic [WORD_W-1:0] slot_out;
    logic              empty, full, do_rd, do_wr;
    mbx_ctrl_t         ctl_d, ctl_q;

    // Occupancy from the 8-bit pointer difference
    assign filled = wptr - rptr;
    assign empty  = (filled == '0);
    assign full   = (filled == DEPTH8);
    assign do_rd  = rd_en && !empty;
    assign do_wr  = wr_en && (!full || do_rd);

    mbx_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk(clk), .rst_n(rst_n), .adv(do_wr), .ptr(wptr), .idx(widx)
    );

    mbx_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk(clk), .rst_n(rst_n), .adv(do_rd), .ptr(rptr), .idx(ridx)
    );

    mbx_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(do_wr), .widx(widx),
        .wdata(pad_word(wr_data, wr_bytes)), .ridx(ridx), .rdata(slot_out)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.notify = notify_req;
        ctl_d.ovf    = ctl_q.ovf | (wr_en && !do_wr);
        if (rd_en) ctl_d.rdata = empty ? '0 : slot_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_data    = ctl_q.rdata;
    assign overflow_o = ctl_q.ovf;
    assign notify_o   = ctl_q.notify;
    assign status     = {DEPTH8, wptr, rptr, 8'h00};
endmodule

// File: rtl/dword_mailbox_chk.sv
module dword_mailbox_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic [31:0] status,
    input logic        overflow_o,
    input logic        notify_o,
    input logic        notify_req
);
    logic [7:0] fill;
    assign fill = status[23:16] - status[15:8];

    // R3: occupancy bounded by depth
    a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= 8'(DEPTH));

    // R6: full buffer without read keeps write pointer and raises overflow
    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && fill == 8'(DEPTH)) |=> ($stable(status[23:16]) && overflow_o));

    // R6: overflow is sticky
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R7: empty read yields zero and keeps read pointer
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fill == 8'd0) |=> (rd_data == 32'd0 && $stable(status[15:8])));

    // R10: notify follows request by one cycle
    a_r10_notify: assert property (@(posedge clk) disable iff (!rst_n)
        notify_req |=> notify_o);

    // R2: low status byte is zero
    a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:0] == 8'h00);
endmodule

bind dword_mailbox dword_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .status(status), .overflow_o(overflow_o), .notify_o(notify_o),
    .notify_req(notify_req)
);

// File: tb/sim_dword_mailbox.sv
module sim_dword_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, notify_req = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wr_bytes = '0;
    logic [31:0] rd_data, status;
    logic        overflow_o, notify_o;

    int n_chk = 0, n_fail = 0;
    logic [31:0] q[$];
    logic [7:0]  m_wp = 0, m_rp = 0;
    logic [31:0] m_rd = 0;
    logic        m_ovf = 0, m_ntf = 0;
    bit          wrapped = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dword_mailbox #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_bytes(wr_bytes), .rd_en(rd_en), .rd_data(rd_data), .status(status),
        .overflow_o(overflow_o), .notify_o(notify_o), .notify_req(notify_req)
    );

    function automatic logic [31:0] exp_pad(logic [31:0] w, logic [1:0] b);
        return (b == 2'd0) ? w : (w & ((32'h1 << (8 * b)) - 32'h1));
    endfunction

    function automatic logic [31:0] exp_status();
        return {8'(DEPTH), m_wp, m_rp, 8'h00};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, model the rising edge, compare at the next falling edge
    task automatic step(bit w, logic [31:0] d, logic [1:0] b, bit r, bit n);
        int f;
        bit emp, ful, dr, dw;
        wr_en = w; wr_data = d; wr_bytes = b; rd_en = r; notify_req = n;
        f   = q.size();
        emp = (f == 0);
        ful = (f == DEPTH);
        dr  = r && !emp;
        dw  = w && (!ful || dr);
        if (r) m_rd = emp ? 32'd0 : q[0];
        if (dr) begin void'(q.pop_front()); m_rp++; end
        if (dw) begin q.push_back(exp_pad(d, b)); if (m_wp == 8'hFF) wrapped = 1; m_wp++; end
        if (w && !dw) m_ovf = 1'b1;
        m_ntf = n;
        @(negedge clk);
        chk("R2/R3 status", status, exp_status());
        chk("R4 rd_data", rd_data, m_rd);
        chk("R6 overflow", 32'(overflow_o), 32'(m_ovf));
        chk("R10 notify", 32'(notify_o), 32'(m_ntf));
        wr_en = 0; rd_en = 0; notify_req = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", status, {8'(DEPTH), 24'h0});
        chk("R1 rd_data", rd_data, 32'd0);
        chk("R1 overflow", 32'(overflow_o), 32'd0);
        chk("R1 notify", 32'(notify_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 empty read
        step(0, 0, 0, 1, 0);
        chk("R7 empty read zero", rd_data, 32'd0);
        // R9 partial words
        step(1, 32'hAABBCCDD, 2'd1, 0, 0);
        step(1, 32'hAABBCCDD, 2'd2, 0, 0);
        step(1, 32'hAABBCCDD, 2'd3, 0, 1);
        step(0, 0, 0, 1, 0);
        chk("R9 one byte", rd_data, 32'h000000DD);
        step(0, 0, 0, 1, 0);
        chk("R9 two bytes", rd_data, 32'h0000CCDD);
        step(0, 0, 0, 1, 0);
        chk("R9 three bytes", rd_data, 32'h00BBCCDD);
        // R8 fill to full then read+write together
        for (int i = 0; i < DEPTH; i++) step(1, 32'h100 + i, 0, 0, 0);
        step(1, 32'hF00D, 0, 1, 0);
        chk("R8 filled stays depth", 32'(status[23:16] - status[15:8]), DEPTH);
        chk("R8 no overflow", 32'(overflow_o), 32'd0);
        chk("R4 oldest", rd_data, 32'h100);
        // R6 write to full
        step(1, 32'hDEAD, 0, 0, 0);
        chk("R6 overflow set", 32'(overflow_o), 32'd1);
        step(0, 0, 0, 0, 0);
        chk("R6 overflow sticky", 32'(overflow_o), 32'd1);
        // drain, then R7 again
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        chk("R7 empty after drain", rd_data, 32'd0);

        // random mix, covers R5 pointer wrap
        for (int i = 0; i < 3000; i++)
            step(1'($urandom % 2), $urandom, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 5 == 0));
        chk("R5 pointer wrapped", 32'(wrapped), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule